// File: doc/BRIEF.md
# Multi-Hit Pulse Timing Extractor over a Sampled Stream

The block receives, on every clock, a word of eight oversampled levels from one input channel and stores it in a circular history that is written without pause. Each sample bit stands for one fixed time bin, and one bin is the least significant unit of every time the block reports. Bit 0 of a word is the earliest bin in that word.

When a trigger arrives, the block places a window in the history. The window starts a programmable number of words before the word being written in the trigger cycle, and its length is also given in words. The block scans the window one word per clock. Each low-to-high transition yields a hit whose arrival time is its bin offset from the window start. The width of the hit is the distance to the next high-to-low transition. At most seven hits are kept per trigger. The hits leave over a valid/ready port as one word each, followed by a closing word that carries the hit count and a flag for dropped edges. Triggers that arrive while a search or readout is under way wait in a short queue. Sampling never stops, so triggers are served with no deadtime.

Top module: `tdc_hit_extract`

## Requirements
- R1: After reset, out_valid_o and trig_lost_o are low.
- R2: A window spans the win_len_i words starting latency_i words before the word sampled in the trigger cycle. A hit's time field is the offset, in bins, of the first high bin of a rising edge from bin 0 of the window (bin = word offset × 8 + bit, bit 0 earliest).
- R3: The width field of a hit is the bin of the first low sample after the rise minus the hit's time.
- R4: If a pulse is still high at the last bin of the window, its width field is 13'h1FFF.
- R5: A pulse that is already high in bin 0 of the window produces no hit.
- R6: At most 7 hits are reported per trigger. Rising edges beyond the seventh are dropped, and they set the overflow flag of the closing word.
- R7: Each trigger produces its hit words in order of arrival time, then one closing word. A hit word is {1'b0, index[2:0], time[12:0], width[12:0]}, with index counting from 0. The closing word is {1'b1, count[2:0], overflow, 25'b0}.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o is held unchanged.
- R9: Triggers that arrive during a search or readout are held in a 4-entry queue and are served in arrival order.
- R10: A trigger that arrives while 4 triggers are pending is discarded, and trig_lost_o is high during the following cycle.
- R11: Sample words are written every cycle during searches and readouts, so a queued trigger reports its own window correctly.
- R12: A trigger with win_len_i equal to 0 produces only a closing word with count 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_i | input | 8 | Sample word for this cycle, bit 0 earliest bin |
| trig_i | input | 1 | Trigger request for this cycle |
| latency_i | input | 10 | Window start distance in words before the trigger-cycle word |
| win_len_i | input | 10 | Window length in words |
| out_ready_i | input | 1 | Consumer accepts out_data_o |
| out_valid_o | output | 1 | out_data_o holds a hit or closing word |
| out_data_o | output | 30 | Hit word or closing word |
| trig_lost_o | output | 1 | A trigger was discarded in the previous cycle |

## Verification
The bench aims first at pulses that cut the window edges. A pulse high in bin 0 must yield no hit; a design that got this wrong would report a time of zero. A pulse still high at the end must report the saturated width and not a truncated count. A pulse that crosses a word boundary exposes a design that restarts edge state at each word. Eight pulses in one window check the cap: a design wrong here would emit an eighth hit or leave the overflow flag clear. A burst of seven back-to-back triggers during a long scan checks that exactly the sixth and seventh are lost and the rest come out in order. Long random runs with stalls on the output check that held words do not change, that windows stay correct after the history wraps, and that queued triggers read their own windows.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int SAMP_W   = 8;
    localparam int ADDR_W   = 10;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int MAX_HITS = 7;
    localparam int IDX_W    = $clog2(MAX_HITS + 1);
    localparam int BIN_W    = $clog2(SAMP_W);
    localparam int TIME_W   = ADDR_W + BIN_W;
    localparam int OUT_W    = 1 + IDX_W + 2 * TIME_W;
    localparam int TQ_DEPTH = 4;
    localparam logic [TIME_W-1:0] SAT_WIDTH = {TIME_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] len;
    } trig_req_t;

    typedef struct packed {
        logic [TIME_W-1:0] t;
        logic [TIME_W-1:0] w;
    } hit_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_EMIT} scan_state_t;

    function automatic logic [OUT_W-1:0] pack_hit(input logic [IDX_W-1:0] idx, input hit_t h);
        return {1'b0, idx, h.t, h.w};
    endfunction

    function automatic logic [OUT_W-1:0] pack_final(input logic [IDX_W-1:0] n, input logic ovf);
        return {1'b1, n, ovf, {(OUT_W - IDX_W - 2){1'b0}}};
    endfunction
endpackage

// File: rtl/tdc_sample_ring.sv
module tdc_sample_ring
    import tdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SAMP_W-1:0] samp_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [SAMP_W-1:0] rd_data_o,
    output logic [ADDR_W-1:0] wr_ptr_o
);
    logic [SAMP_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;

    always_ff @(posedge clk) begin
        mem[wr_ptr] <= samp_i;
    end

    always_ff @(posedge clk) begin
        if (rst) wr_ptr <= '0;
        else     wr_ptr <= wr_ptr + ADDR_W'(1);
    end

    assign rd_data_o = mem[rd_addr_i];
    assign wr_ptr_o  = wr_ptr;

    AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> wr_ptr == $past(wr_ptr) + ADDR_W'(1)); // R11
endmodule

// File: rtl/tdc_trig_fifo.sv
module tdc_trig_fifo
    import tdc_pkg::*;
#(
    parameter int QDEPTH = TQ_DEPTH
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push_i,
    input  trig_req_t req_i,
    input  logic      pop_i,
    output logic      nonempty_o,
    output trig_req_t head_o,
    output logic      lost_o
);
    localparam int PTR_W = $clog2(QDEPTH);
    localparam int CNT_W = $clog2(QDEPTH + 1);

    trig_req_t        slots [QDEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full, push_ok, pop_ok, lost_q;

    assign full    = (cnt == CNT_W'(QDEPTH));
    assign push_ok = push_i && !full;
    assign pop_ok  = pop_i && (cnt != '0);

    always_ff @(posedge clk) begin
        if (push_ok) slots[wr_ptr] <= req_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            lost_q <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(QDEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(QDEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            cnt    <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
            lost_q <= push_i && full;
        end
    end

    assign nonempty_o = (cnt != '0);
    assign head_o     = slots[rd_ptr];
    assign lost_o     = lost_q;

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(QDEPTH)); // R9
    AST_LOST_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        lost_o |-> $past(cnt) == CNT_W'(QDEPTH)); // R10
endmodule

// File: rtl/tdc_edge_scan.sv
module tdc_edge_scan
    import tdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  trig_req_t         req_i,
    output logic              pop_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [SAMP_W-1:0] rd_data_i,
    output logic              out_valid_o,
    output logic [OUT_W-1:0]  out_data_o,
    input  logic              out_ready_i
);
    scan_state_t       state;
    logic [ADDR_W-1:0] base, len, k;
    logic              prev, open;
    logic [IDX_W-1:0]  cur_idx, cnt, emit_idx, sel;
    logic              ovf;
    hit_t              hits [MAX_HITS];

    logic              n_prev, n_open, n_ovf;
    logic [IDX_W-1:0]  n_idx, n_cnt;
    hit_t              n_hits [MAX_HITS];
    logic [TIME_W-1:0] tnow;

    assign pop_o     = (state == ST_IDLE) && req_valid_i;
    assign rd_addr_o = base + k;

    // Edge detection over the eight bins of the current word, earliest first
    always_comb begin
        n_prev = prev;
        n_open = open;
        n_idx  = cur_idx;
        n_cnt  = cnt;
        n_ovf  = ovf;
        n_hits = hits;
        tnow   = '0;
        for (int b = 0; b < SAMP_W; b++) begin
            tnow = {k, BIN_W'(b)};
            if (k == '0 && b == 0) begin
                n_prev = rd_data_i[b];
            end else begin
                if (!n_prev && rd_data_i[b]) begin
                    if (n_cnt != IDX_W'(MAX_HITS)) begin
                        n_hits[n_cnt].t = tnow;
                        n_hits[n_cnt].w = SAT_WIDTH;
                        n_idx  = n_cnt;
                        n_open = 1'b1;
                        n_cnt  = n_cnt + IDX_W'(1);
                    end else begin
                        n_ovf = 1'b1;
                    end
                end else if (n_prev && !rd_data_i[b] && n_open) begin
                    n_hits[n_idx].w = tnow - n_hits[n_idx].t;
                    n_open = 1'b0;
                end
                n_prev = rd_data_i[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            base     <= '0;
            len      <= '0;
            k        <= '0;
            prev     <= 1'b0;
            open     <= 1'b0;
            cur_idx  <= '0;
            cnt      <= '0;
            ovf      <= 1'b0;
            emit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        base     <= req_i.start;
                        len      <= req_i.len;
                        k        <= '0;
                        open     <= 1'b0;
                        cnt      <= '0;
                        ovf      <= 1'b0;
                        emit_idx <= '0;
                        state    <= (req_i.len == '0) ? ST_EMIT : ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    prev    <= n_prev;
                    open    <= n_open;
                    cur_idx <= n_idx;
                    cnt     <= n_cnt;
                    ovf     <= n_ovf;
                    hits    <= n_hits;
                    k       <= k + ADDR_W'(1);
                    if (k == len - ADDR_W'(1)) state <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (out_ready_i) begin
                        if (emit_idx == cnt) state <= ST_IDLE;
                        else                 emit_idx <= emit_idx + IDX_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sel         = (emit_idx == IDX_W'(MAX_HITS)) ? '0 : emit_idx;
    assign out_valid_o = (state == ST_EMIT);
    assign out_data_o  = (emit_idx == cnt) ? pack_final(cnt, ovf) : pack_hit(emit_idx, hits[sel]);

    logic              o_final;
    logic [TIME_W-1:0] o_time, o_width;
    logic [TIME_W:0]   win_bins;
    assign o_final  = out_data_o[OUT_W-1];
    assign o_time   = out_data_o[2*TIME_W-1 -: TIME_W];
    assign o_width  = out_data_o[TIME_W-1:0];
    assign win_bins = {1'b0, len, BIN_W'(0)};

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R8
    AST_NO_BIN0_HIT: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !o_final |-> o_time != '0); // R5
    AST_WIDTH_FIT: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !o_final && o_width != SAT_WIDTH |->
        ({1'b0, o_time} + {1'b0, o_width}) < win_bins); // R3
    AST_OVF_AT_CAP: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && o_final && out_data_o[OUT_W-2-IDX_W] |->
        out_data_o[OUT_W-2 -: IDX_W] == IDX_W'(MAX_HITS)); // R6
    AST_FINAL_LAST: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && o_final && out_ready_i |=> !out_valid_o); // R7
endmodule

// File: rtl/tdc_hit_extract.sv
module tdc_hit_extract
    import tdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SAMP_W-1:0] samp_i,
    input  logic              trig_i,
    input  logic [ADDR_W-1:0] latency_i,
    input  logic [ADDR_W-1:0] win_len_i,
    input  logic              out_ready_i,
    output logic              out_valid_o,
    output logic [OUT_W-1:0]  out_data_o,
    output logic              trig_lost_o
);
    logic [ADDR_W-1:0] wr_ptr, rd_addr;
    logic [SAMP_W-1:0] rd_data;
    trig_req_t         new_req, head;
    logic              q_nonempty, pop;

    assign new_req.start = wr_ptr - latency_i;
    assign new_req.len   = win_len_i;

    tdc_sample_ring u_ring (
        .clk       (clk),
        .rst       (rst),
        .samp_i    (samp_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_ptr_o  (wr_ptr)
    );

    tdc_trig_fifo #(.QDEPTH(TQ_DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push_i     (trig_i),
        .req_i      (new_req),
        .pop_i      (pop),
        .nonempty_o (q_nonempty),
        .head_o     (head),
        .lost_o     (trig_lost_o)
    );

    tdc_edge_scan u_scan (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (q_nonempty),
        .req_i       (head),
        .pop_o       (pop),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o),
        .out_ready_i (out_ready_i)
    );
endmodule

// File: tb/tdc_hit_extract_tb.sv
module tdc_hit_extract_tb;
    import tdc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [SAMP_W-1:0] samp = '0;
    logic              trig = 1'b0;
    logic [ADDR_W-1:0] lat = '0, wlen = '0;
    logic              rdy = 1'b1;
    logic              out_valid, lost;
    logic [OUT_W-1:0]  out_data;

    tdc_hit_extract u_dut (
        .clk(clk), .rst(rst), .samp_i(samp), .trig_i(trig),
        .latency_i(lat), .win_len_i(wlen), .out_ready_i(rdy),
        .out_valid_o(out_valid), .out_data_o(out_data), .trig_lost_o(lost)
    );

    always #5 clk = ~clk;

    int               errors = 0, checks = 0, wn = 0, ready_pct = 100;
    logic [7:0]       hist [0:19999];
    logic [OUT_W-1:0] expq [$];
    bit               lost_exp_prev = 0, hold_pend = 0, level = 0;
    logic [OUT_W-1:0] hold_data;
    string            tag = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: walk the window bin by bin
    task automatic model(input int wstart, input int nwords);
        int cnt = 0, idx = 0;
        bit ovf = 0, open = 0, prev = 0, b;
        int tt [7];
        int ww [7];
        for (int j = 0; j < nwords * 8; j++) begin
            b = hist[wstart + j / 8][j % 8];
            if (j == 0) prev = b;
            else begin
                if (!prev && b) begin
                    if (cnt < 7) begin
                        tt[cnt] = j; ww[cnt] = 'h1FFF; idx = cnt; open = 1; cnt++;
                    end else ovf = 1;
                end else if (prev && !b && open) begin
                    ww[idx] = j - tt[idx]; open = 0;
                end
                prev = b;
            end
        end
        for (int i = 0; i < cnt; i++)
            expq.push_back({1'b0, 3'(i), 13'(tt[i]), 13'(ww[i])});
        expq.push_back({1'b1, 3'(cnt), ovf, 25'b0});
    endtask

    function automatic logic [7:0] gen_word();
        logic [7:0] w;
        for (int b = 0; b < 8; b++) begin
            if ($urandom % 6 == 0) level = ~level;
            w[b] = level;
        end
        return w;
    endfunction

    task automatic step(input logic [7:0] s, input bit tr, input bit tr_lost);
        logic [OUT_W-1:0] e;
        @(negedge clk);
        samp = s;
        trig = tr;
        hist[wn] = s;
        rdy = ($urandom % 100) < ready_pct;
        if (tr && !tr_lost) model(wn - int'(lat), int'(wlen));
        wn++;
        #1;
        check(lost == lost_exp_prev, "R10", "trig_lost", 64'(lost), 64'(lost_exp_prev));
        lost_exp_prev = tr && tr_lost;
        if (hold_pend)
            check(out_valid && out_data == hold_data, "R8", "held word",
                  64'({out_valid, out_data}), 64'({1'b1, hold_data}));
        hold_pend = out_valid && !rdy;
        hold_data = out_data;
        if (out_valid && rdy) begin
            if (expq.size() == 0) check(0, tag, "unexpected word", 64'(out_data), 0);
            else begin
                e = expq.pop_front();
                check(out_data == e, tag, "output word", 64'(out_data), 64'(e));
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 3000 && (expq.size() != 0 || out_valid); i++)
            step(gen_word(), 0, 0);
        step(gen_word(), 0, 0);
    endtask

    task automatic directed(input logic [7:0] w0, w1, w2, w3, input string t);
        tag = t;
        step(w0, 0, 0); step(w1, 0, 0); step(w2, 0, 0); step(w3, 0, 0);
        repeat (4) step(8'h00, 0, 0);
        step(8'h00, 1, 0);
        drain();
    endtask

    initial begin
        #1_500_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) step(8'h00, 0, 0);
        rst = 1'b0;
        step(8'h00, 0, 0);
        check(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 0);
        check(!lost, "R1", "trig_lost after reset", 64'(lost), 0);
        repeat (80) step(gen_word(), 0, 0);

        lat = 10'd8; wlen = 10'd4;
        // R2 R3: pulse inside a word, pulse across a word boundary
        directed(8'h00, 8'h18, 8'hC0, 8'h03, "R2/R3/R7");
        // R4 R5: high at bin 0, still high at the last bin
        directed(8'h01, 8'h00, 8'h00, 8'h80, "R4/R5");
        // R6: eight rises, the eighth dropped with overflow set
        directed(8'hAA, 8'hAA, 8'h00, 8'h00, "R6");
        // R6: exactly seven rises, no overflow
        directed(8'hAA, 8'h2A, 8'h00, 8'h00, "R6 at cap");
        // R12: empty window
        wlen = 10'd0;
        directed(8'hFF, 8'h00, 8'hFF, 8'h00, "R12");

        // R9 R10: seven triggers back to back during a long scan
        lat = 10'd64; wlen = 10'd48; tag = "R9/R10";
        repeat (70) step(gen_word(), 0, 0);
        for (int i = 0; i < 7; i++) step(gen_word(), 1, i >= 5);
        drain();

        // R11 R8: random pulses, stalls, queued triggers, history wrap
        lat = 10'd40; wlen = 10'd20; ready_pct = 70; tag = "R11/R8";
        for (int i = 0; i < 1500; i++)
            step(gen_word(), (i % 50 == 0) || (i % 200 == 3) || (i % 200 == 4), 0);
        ready_pct = 100;
        drain();

        check(expq.size() == 0, "R9", "words still owed", 64'(expq.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule